// File: doc/BRIEF.md
# Pin-Level Fuse Array Read Port

This block puts every control pin of a one-time-programmable fuse macro under direct software control through a small 32-bit register bus. A control word carries an active-low select, a strobe, a load line, an active-low program-enable line and a 10-bit byte address. A data-out register presents the fuse byte captured at the most recent qualifying strobe edge. The block contains a read-only behavioural model of a 1024-byte fuse array whose contents come from a fixed arithmetic pattern.

Software sequences a read by hand. It first writes the control word with load high, program enable high and select low, which puts the macro in read mode. For each byte it then sets the address, raises the strobe, reads data-out, and drops the strobe again. To leave read mode it writes select and program enable high with load and strobe low, which is the standby state. The block has no automatic sequencer. A byte is latched only on the low-to-high transition of the strobe pin while the macro is in read mode.

Top module: `fuse_pin_reader`

## Requirements
- R1: After synchronous reset the control register reads 0x0000_0009 (select high, program enable high: standby), data-out reads 0, and read data is 0.
- R2: A write to offset 0x0 stores all 32 bits, and a later read of offset 0x0 returns that value unchanged.
- R3: A read of offset 0x4 returns the captured byte in bits 7:0 with bits 31:8 zero.
- R4: Control bits are select_n = bit 0, strobe = bit 1, load = bit 2, pgen_n = bit 3 and byte address = bits 15:6. When strobe goes from 0 to 1 while select_n = 0, load = 1 and pgen_n = 1, data-out takes the fuse byte at that address.
- R5: A strobe rising edge while select_n = 1 leaves data-out unchanged.
- R6: A strobe rising edge while load = 0 leaves data-out unchanged.
- R7: A strobe rising edge while pgen_n = 0 (program state) leaves data-out unchanged.
- R8: While strobe stays high, changing the address does not update data-out; a capture needs a fresh 0-to-1 transition.
- R9: Writes to any offset other than 0x0, including data-out at 0x4, change no register. Reads of unmapped offsets return 0.
- R10: Read data is registered: it appears on the clock edge that samples the read enable, and it holds its value while read enable is low.
- R11: Fuse byte at address a equals ((a*37 + (a >> 8)) mod 256) XOR 0x5A for every a from 0 to 1023, including both ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |

## Verification
Strobe pulses are driven with each pin combination of interest: proper read mode, select deasserted, load low, program enable asserted, and full standby. Each of these must either capture the byte or leave data-out alone, so a decode that ignores any one pin is exposed. The read-mode addresses include 0, 1, 255, 256, 700 and 1023. These cover both address ends and the carry into the upper address bits, and they catch a misplaced address field or a wrong fuse pattern. A held strobe with a changing address separates edge capture from level capture.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

    localparam int DATA_W  = 32;
    localparam int BUS_AW  = 8;
    localparam int FUSE_AW = 10;
    localparam int BYTE_W  = 8;

    // Control word bit positions (decoded by the fuse macro pins)
    localparam int SEL_N_BIT  = 0;
    localparam int STROBE_BIT = 1;
    localparam int LOAD_BIT   = 2;
    localparam int PGEN_N_BIT = 3;
    localparam int ADDR_LSB   = 6;
    localparam int ADDR_MSB   = ADDR_LSB + FUSE_AW - 1;

    localparam logic [BUS_AW-1:0] OFS_CTRL = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_DOUT = 8'h04;

    // Standby: select and program enable both deasserted (high)
    localparam logic [DATA_W-1:0] CTRL_RESET =
        DATA_W'((1 << SEL_N_BIT) | (1 << PGEN_N_BIT));

    typedef struct packed {
        logic               sel_n;
        logic               strobe;
        logic               load;
        logic               pgen_n;
        logic [FUSE_AW-1:0] addr;
    } pins_t;

    typedef enum logic [1:0] {
        MODE_STANDBY,
        MODE_READ,
        MODE_PROGRAM,
        MODE_IDLE
    } mode_t;

    function automatic pins_t unpack_ctrl(input logic [DATA_W-1:0] w);
        pins_t p;
        p.sel_n  = w[SEL_N_BIT];
        p.strobe = w[STROBE_BIT];
        p.load   = w[LOAD_BIT];
        p.pgen_n = w[PGEN_N_BIT];
        p.addr   = w[ADDR_MSB:ADDR_LSB];
        return p;
    endfunction

    function automatic mode_t decode_mode(input pins_t p);
        mode_t m;
        if (p.sel_n)
            m = MODE_STANDBY;
        else if (!p.pgen_n)
            m = MODE_PROGRAM;
        else if (p.load)
            m = MODE_READ;
        else
            m = MODE_IDLE;
        return m;
    endfunction

    // Constant content of the behavioural fuse array
    function automatic logic [BYTE_W-1:0] fuse_pattern(input logic [FUSE_AW-1:0] a);
        logic [BYTE_W-1:0] lo;
        lo = BYTE_W'(a * 10'd37);
        return (lo + BYTE_W'(a[FUSE_AW-1:8])) ^ 8'h5A;
    endfunction

endpackage

// File: rtl/fuse_rd_array.sv
module fuse_rd_array
    import fuse_rd_pkg::*;
#(
    parameter int AW = FUSE_AW,
    parameter int DW = BYTE_W
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);

    // Read-only array: contents fixed by the package pattern
    always_comb begin
        data = DW'(fuse_pattern(FUSE_AW'(addr)));
    end

endmodule

// File: rtl/fuse_rd_capture.sv
module fuse_rd_capture
    import fuse_rd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = FUSE_AW,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] ctrl_word,
    input  logic [BW-1:0] fuse_byte,
    output logic [AW-1:0] fuse_addr,
    output logic [DW-1:0] dout_word
);

    pins_t         pins;
    mode_t         mode;
    logic          strobe_prev;
    logic          strobe_rise;
    logic [BW-1:0] held_byte;
    logic          unused_ctrl_bits;

    assign pins             = unpack_ctrl(ctrl_word);
    assign mode             = decode_mode(pins);
    assign fuse_addr        = AW'(pins.addr);
    assign strobe_rise      = pins.strobe & ~strobe_prev;
    assign unused_ctrl_bits = ^{ctrl_word[DW-1:ADDR_MSB+1], ctrl_word[ADDR_LSB-1:PGEN_N_BIT+1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_prev <= 1'b0;
            held_byte   <= '0;
        end else begin
            strobe_prev <= pins.strobe;
            if (strobe_rise && mode == MODE_READ)
                held_byte <= fuse_byte;
        end
    end

    assign dout_word = {{(DW-BW){1'b0}}, held_byte};

endmodule

// File: rtl/fuse_rd_regs.sv
module fuse_rd_regs
    import fuse_rd_pkg::*;
#(
    parameter int AW = BUS_AW,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_re,
    input  logic [DW-1:0] dout_word,
    output logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] ctrl_word
);

    logic [DW-1:0] rd_mux;

    always_comb begin
        case (bus_addr)
            AW'(OFS_CTRL): rd_mux = ctrl_word;
            AW'(OFS_DOUT): rd_mux = dout_word;
            default:       rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_word <= DW'(CTRL_RESET);
            bus_rdata <= '0;
        end else begin
            if (bus_we && bus_addr == AW'(OFS_CTRL))
                ctrl_word <= bus_wdata;
            if (bus_re)
                bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/fuse_pin_reader.sv
module fuse_pin_reader
    import fuse_rd_pkg::*;
#(
    parameter int AW  = BUS_AW,
    parameter int DW  = DATA_W,
    parameter int FAW = FUSE_AW,
    parameter int BW  = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_re,
    output logic [DW-1:0] bus_rdata
);

    logic [DW-1:0]  ctrl_word;
    logic [DW-1:0]  dout_word;
    logic [FAW-1:0] fuse_addr;
    logic [BW-1:0]  fuse_byte;

    fuse_rd_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .dout_word (dout_word),
        .bus_rdata (bus_rdata),
        .ctrl_word (ctrl_word)
    );

    fuse_rd_capture #(.DW(DW), .AW(FAW), .BW(BW)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .ctrl_word (ctrl_word),
        .fuse_byte (fuse_byte),
        .fuse_addr (fuse_addr),
        .dout_word (dout_word)
    );

    fuse_rd_array #(.AW(FAW), .DW(BW)) u_array (
        .addr (fuse_addr),
        .data (fuse_byte)
    );

endmodule

// File: rtl/fuse_pin_reader_chk.sv
module fuse_pin_reader_chk
    import fuse_rd_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [BUS_AW-1:0]   bus_addr,
    input logic                bus_we,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                bus_re,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [DATA_W-1:0]   ctrl_q,
    input logic [DATA_W-1:0]   dout_q
);

    a_r2_ctrl_store: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_CTRL) |=> ctrl_q == $past(bus_wdata));

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == OFS_DOUT) |=> bus_rdata[DATA_W-1:BYTE_W] == '0);

    a_r4_capture_byte: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[STROBE_BIT] && !$past(ctrl_q[STROBE_BIT]) && !ctrl_q[SEL_N_BIT]
         && ctrl_q[LOAD_BIT] && ctrl_q[PGEN_N_BIT])
        |=> dout_q[BYTE_W-1:0] == fuse_pattern($past(ctrl_q[ADDR_MSB:ADDR_LSB])));

    a_r5_deselect_hold: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[SEL_N_BIT] |=> $stable(dout_q));

    a_r6_noload_hold: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[LOAD_BIT] |=> $stable(dout_q));

    a_r7_program_hold: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[PGEN_N_BIT] |=> $stable(dout_q));

    a_r8_level_hold: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[STROBE_BIT] && $past(ctrl_q[STROBE_BIT])) |=> $stable(dout_q));

    a_r9_other_write: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr != OFS_CTRL) |=> $stable(ctrl_q));

    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> $stable(bus_rdata));

endmodule

bind fuse_pin_reader fuse_pin_reader_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .ctrl_q    (ctrl_word),
    .dout_q    (dout_word)
);

// File: tb/fuse_pin_reader_test.sv
`timescale 1ns/1ps
module fuse_pin_reader_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    fuse_pin_reader uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata)
    );

    typedef struct packed {
        logic [31:0] ctrl;
        logic        cap;
    } vec_t;

    // Control word with strobe low; strobe is raised by the loop
    localparam vec_t VECS [10] = '{
        '{32'h0000_000C, 1'b1},  // read, addr 0
        '{32'h0000_004C, 1'b1},  // read, addr 1
        '{32'h0000_3FCC, 1'b1},  // read, addr 255
        '{32'h0000_400C, 1'b1},  // read, addr 256
        '{32'h0000_014D, 1'b0},  // select high, addr 5
        '{32'h0000_AF0C, 1'b1},  // read, addr 700
        '{32'h0000_0248, 1'b0},  // load low, addr 9
        '{32'h0000_0244, 1'b0},  // program enable low, addr 9
        '{32'h0000_FFCC, 1'b1},  // read, addr 1023
        '{32'h0000_0089, 1'b0}   // standby, addr 2
    };

    function automatic int exp_fuse(input int a);
        return (((a * 37) + (a >> 8)) & 255) ^ 'h5A;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] exp_dout;
        logic [31:0] held;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 rdata after reset", bus_rdata, 32'h0);
        bus_read(8'h00, rd);
        chk("R1 ctrl reset", rd, 32'h0000_0009);
        bus_read(8'h04, rd);
        chk("R1 dout reset", rd, 32'h0);

        // Table: modes and addresses (R4 R5 R6 R7 R11 R3)
        exp_dout = 32'h0;
        for (int i = 0; i < 10; i++) begin
            int a;
            a = int'((VECS[i].ctrl >> 6) & 32'h3FF);
            bus_write(8'h00, VECS[i].ctrl);
            bus_write(8'h00, VECS[i].ctrl | 32'h2);
            if (VECS[i].cap)
                exp_dout = 32'(exp_fuse(a));
            bus_read(8'h04, rd);
            chk($sformatf("R%0d vector %0d addr %0d", VECS[i].cap ? 4 : 5, i, a), rd, exp_dout);
            chk("R3 upper bits zero", {8'h0, rd[31:8]}, 32'h0);
            bus_write(8'h00, VECS[i].ctrl);
        end

        // R11: both address ends checked directly
        bus_write(8'h00, 32'h0000_FFCC);
        bus_write(8'h00, 32'h0000_FFCE);
        bus_read(8'h04, rd);
        chk("R11 addr 1023", rd, 32'(exp_fuse(1023)));
        bus_write(8'h00, 32'h0000_000C);
        bus_write(8'h00, 32'h0000_000E);
        bus_read(8'h04, rd);
        chk("R11 addr 0", rd, 32'(exp_fuse(0)));

        // R8: strobe held high, address moves, no new capture
        bus_write(8'h00, 32'h0000_004E);
        bus_read(8'h04, rd);
        chk("R8 held strobe", rd, 32'(exp_fuse(0)));
        bus_write(8'h00, 32'h0000_AF0E);
        bus_read(8'h04, rd);
        chk("R8 held strobe second move", rd, 32'(exp_fuse(0)));

        // R10: rdata holds with read enable low
        held = bus_rdata;
        bus_write(8'h00, 32'h0000_004C);
        bus_write(8'h00, 32'h0000_004E);
        chk("R10 rdata holds", bus_rdata, held);
        bus_read(8'h04, rd);
        chk("R10 fresh read after capture", rd, 32'(exp_fuse(1)));

        // R9: writes elsewhere ignored, unmapped reads zero
        bus_write(8'h00, 32'h0000_0009);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_read(8'h04, rd);
        chk("R9 dout write ignored", rd, 32'(exp_fuse(1)));
        bus_write(8'h08, 32'h1234_5678);
        bus_read(8'h00, rd);
        chk("R9 unmapped write ignored", rd, 32'h0000_0009);
        bus_read(8'h08, rd);
        chk("R9 unmapped read zero", rd, 32'h0);

        // R2: full-width readback
        bus_write(8'h00, 32'hA5A5_1231);
        bus_read(8'h00, rd);
        chk("R2 readback pattern", rd, 32'hA5A5_1231);
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_read(8'h00, rd);
        chk("R2 readback ones", rd, 32'hFFFF_FFFF);
        bus_read(8'h04, rd);
        chk("R5 select high strobe rise", rd, 32'(exp_fuse(1)));

        done = 1;
        finish_run();
    end

endmodule